// File: doc/BRIEF.md
# Texture Cache Maintenance Controller

This block sits beside a texture L2 cache and performs maintenance on it when software asks. It holds one control register: a single write picks one of three line operations and may also request that an upstream L1 write combiner be emptied first. Once the command is taken, the block walks the cache's per-line valid/dirty state, one line per cycle. It raises a write-back request for each dirty line whose data must reach memory and waits for the memory side to acknowledge it. It then updates the line's state and moves on.

While a command is in progress, the busy bit in the control register reads 1. Cache lookups made during that time are held with a stall indication and are not rejected. They complete in the normal way once the operation ends. The lookup port also stands in for normal cache traffic. A lookup marks its line valid, and a write lookup also marks it dirty. This lets the maintenance walk act on a realistic mix of clean, dirty and empty lines.

Top module: `tcm_ctrl`

## Requirements
- R1: After reset, busy reads 0, no write-back or write-combiner flush request is raised, the whole control register reads 0, and every line is invalid, so a lookup misses.
- R2: The control register is at byte address 0x30. In a write, bit 0 starts a line operation, bits 2:1 select the mode, and bit 8 requests a write-combiner flush. When read, bit 0 is busy, bits 2:1 are the mode of the last accepted start, and bit 8 is 1 while the flush phase runs. Writes to any other address have no effect, and reads of any other address return 0.
- R3: Mode 0 (invalidate) writes back every valid dirty line and leaves all lines invalid.
- R4: Mode 1 (discard) issues no write-back and leaves all lines invalid.
- R5: Mode 2 (clean) writes back every valid dirty line and leaves it valid and clean, so a second clean issues no write-back.
- R6: The walk visits lines in ascending order, one per cycle. With no write-backs, busy reads 1 for exactly LINES cycles, starting the cycle after the accepted write.
- R7: A write-back request holds steady, with the same line index, until it is acknowledged. The walk then continues with the next line.
- R8: Writes to the control register while busy is 1 are ignored. They start nothing and do not change the mode field.
- R9: With bit 8 set, the flush request is raised the cycle after the write and held until the flush-done input is seen. No line is walked before then, and busy stays 1 throughout. A write with only bit 8 set performs only the flush.
- R10: A lookup made while busy is 1 shows stall high and done low, and does not change the line state. It completes normally after busy clears.
- R11: A start with mode 3 begins no line operation.
- R12: A lookup reports a hit when its line is valid. The line then becomes valid, and it becomes dirty as well when the lookup is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, a combinational function of reg_addr |
| wc_flush_req | output | 1 | Request to drain the L1 write combiner |
| wc_flush_done | input | 1 | Write-combiner drain finished |
| wb_req | output | 1 | Write-back request for one dirty line |
| wb_line | output | IDX_W | Line index of the write-back |
| wb_ack | input | 1 | Write-back accepted by memory |
| lk_valid | input | 1 | Cache lookup present |
| lk_idx | input | IDX_W | Lookup line index |
| lk_write | input | 1 | Lookup is a write, marking the line dirty |
| lk_stall | output | 1 | Lookup held because an operation is running |
| lk_done | output | 1 | Lookup completes this cycle |
| lk_hit | output | 1 | Completed lookup found its line valid |

## Verification
Each of the three modes is run over the same mix of dirty, clean and empty lines, which separates write-back-then-invalidate, plain discard and write-back-keep-valid. Sparse masks at both ends of the index range, and a fully dirty cache, test that the walk order and acknowledge stepping hold from the first line to the last. Some runs place the write-combiner flush before the walk, to confirm that no line moves before the flush completes. Directed cases cover the exact busy length, writes made while busy, the reserved mode, a lookup caught mid-operation and a repeated clean.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
   typedef enum logic [1:0] {
      MODE_INVAL   = 2'd0,
      MODE_DISCARD = 2'd1,
      MODE_CLEAN   = 2'd2,
      MODE_RSVD    = 2'd3
   } tcm_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WCF  = 2'd1,
      ST_WALK = 2'd2,
      ST_WB   = 2'd3
   } tcm_state_e;

   // control register bit positions (software-visible encoding)
   localparam int CTL_START_BIT = 0;
   localparam int CTL_MODE_LSB  = 1;
   localparam int CTL_WCF_BIT   = 8;

   typedef struct packed {
      logic      start;
      tcm_mode_e mode;
      logic      wcf;
   } tcm_cmd_t;
endpackage

// File: rtl/tcm_regif.sv
module tcm_regif
   import tcm_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 32,
   parameter int CTRL_OFFSET = 'h30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              busy,
   input  logic              wcf_active,
   output logic              cmd_valid,
   output tcm_cmd_t          cmd,
   output logic [DATA_W-1:0] reg_rdata
);
   localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CTRL_OFFSET);

   logic      addr_hit;
   logic      accept;
   tcm_mode_e mode_q;
   logic      unused_wdata_bits;

   assign addr_hit = (reg_addr == CTRL_ADDR);
   assign accept   = reg_wr_en && addr_hit && !busy;

   always_comb begin
      cmd.mode  = tcm_mode_e'(reg_wdata[CTL_MODE_LSB +: 2]);
      cmd.start = reg_wdata[CTL_START_BIT] && (cmd.mode != MODE_RSVD);
      cmd.wcf   = reg_wdata[CTL_WCF_BIT];
   end

   assign cmd_valid = accept && (cmd.start || cmd.wcf);

   always_ff @(posedge clk) begin
      if (!rst_n)
         mode_q <= MODE_INVAL;
      else if (accept && cmd.start)
         mode_q <= cmd.mode;
   end

   always_comb begin
      reg_rdata = '0;
      if (addr_hit) begin
         reg_rdata[CTL_START_BIT]       = busy;
         reg_rdata[CTL_MODE_LSB +: 2]   = mode_q;
         reg_rdata[CTL_WCF_BIT]         = wcf_active;
      end
   end

   assign unused_wdata_bits = ^{reg_wdata[DATA_W-1:CTL_WCF_BIT+1],
                                reg_wdata[CTL_WCF_BIT-1:CTL_MODE_LSB+2]};

   // R8
   busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_wr_en) |=> $stable(mode_q));
endmodule

// File: rtl/tcm_line_array.sv
module tcm_line_array #(
   parameter int LINES = 16,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_upd,
   input  logic [IDX_W-1:0] lk_idx,
   input  logic             lk_write,
   input  logic             mt_upd,
   input  logic [IDX_W-1:0] mt_idx,
   input  logic             mt_keep_valid,
   output logic [LINES-1:0] valid_vec,
   output logic [LINES-1:0] dirty_vec
);
   for (genvar i = 0; i < LINES; i++) begin : g_line
      logic mt_sel;
      logic lk_sel;
      assign mt_sel = mt_upd && (mt_idx == IDX_W'(i));
      assign lk_sel = lk_upd && (lk_idx == IDX_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_vec[i] <= 1'b0;
            dirty_vec[i] <= 1'b0;
         end else if (mt_sel) begin
            valid_vec[i] <= mt_keep_valid ? valid_vec[i] : 1'b0;
            dirty_vec[i] <= 1'b0;
         end else if (lk_sel) begin
            valid_vec[i] <= 1'b1;
            dirty_vec[i] <= dirty_vec[i] | lk_write;
         end
      end
   end

   // R10
   no_lookup_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_upd |-> !mt_upd);

   // R4
   drop_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mt_upd && !mt_keep_valid) |=> !valid_vec[$past(mt_idx)] && !dirty_vec[$past(mt_idx)]);
endmodule

// File: rtl/tcm_seq.sv
module tcm_seq
   import tcm_pkg::*;
#(
   parameter int LINES       = 16,
   parameter bit WB_ON_INVAL = 1'b1,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  tcm_cmd_t         cmd,
   input  logic             wcf_done,
   input  logic             wb_ack,
   input  logic             line_valid,
   input  logic             line_dirty,
   output logic             busy,
   output logic             wcf_active,
   output logic             wb_req,
   output logic [IDX_W-1:0] line_idx,
   output logic             mt_upd,
   output logic             mt_keep_valid
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

   tcm_state_e st;
   tcm_mode_e  op_mode;
   logic       pend_start;
   logic [IDX_W-1:0] idx;
   logic       mode_wb;
   logic       need_wb;
   logic       advance;

   if (WB_ON_INVAL) begin : g_inval_wb
      assign mode_wb = (op_mode != MODE_DISCARD);
   end else begin : g_inval_drop
      assign mode_wb = (op_mode == MODE_CLEAN);
   end

   assign need_wb = mode_wb && line_valid && line_dirty;
   assign advance = ((st == ST_WALK) && !need_wb) || ((st == ST_WB) && wb_ack);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         op_mode    <= MODE_INVAL;
         pend_start <= 1'b0;
         idx        <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (cmd_valid) begin
                  op_mode    <= cmd.mode;
                  pend_start <= cmd.start;
                  idx        <= '0;
                  st         <= cmd.wcf ? ST_WCF : ST_WALK;
               end
            end
            ST_WCF: begin
               if (wcf_done)
                  st <= pend_start ? ST_WALK : ST_IDLE;
            end
            ST_WALK, ST_WB: begin
               if (st == ST_WALK && need_wb) begin
                  st <= ST_WB;
               end else if (advance) begin
                  if (idx == LAST_IDX) begin
                     st <= ST_IDLE;
                  end else begin
                     idx <= idx + 1'b1;
                     st  <= ST_WALK;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy          = (st != ST_IDLE);
   assign wcf_active    = (st == ST_WCF);
   assign wb_req        = (st == ST_WB);
   assign line_idx      = idx;
   assign mt_upd        = advance;
   assign mt_keep_valid = (op_mode == MODE_CLEAN);

   // R7
   wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_req && !wb_ack) |=> wb_req && (line_idx == $past(line_idx)));

   // R6
   walk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_WALK) && !need_wb && (idx != LAST_IDX)) |=>
         (line_idx == IDX_W'($past(line_idx) + 1'b1)));
endmodule

// File: rtl/tcm_ctrl.sv
module tcm_ctrl
   import tcm_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 32,
   parameter int CTRL_OFFSET = 'h30,
   parameter int LINES       = 16,
   parameter bit WB_ON_INVAL = 1'b1,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              wc_flush_req,
   input  logic              wc_flush_done,
   output logic              wb_req,
   output logic [IDX_W-1:0]  wb_line,
   input  logic              wb_ack,
   input  logic              lk_valid,
   input  logic [IDX_W-1:0]  lk_idx,
   input  logic              lk_write,
   output logic              lk_stall,
   output logic              lk_done,
   output logic              lk_hit
);
   if (LINES < 2) begin : g_bad_lines
      $error("tcm_ctrl: LINES must be at least 2");
   end
   if (DATA_W < CTL_WCF_BIT + 1) begin : g_bad_width
      $error("tcm_ctrl: DATA_W too narrow for control fields");
   end
   if (CTRL_OFFSET >= (1 << ADDR_W)) begin : g_bad_offset
      $error("tcm_ctrl: CTRL_OFFSET outside address range");
   end

   logic             busy;
   logic             cmd_valid;
   tcm_cmd_t         cmd;
   logic [IDX_W-1:0] line_idx;
   logic             mt_upd;
   logic             mt_keep_valid;
   logic [LINES-1:0] valid_vec;
   logic [LINES-1:0] dirty_vec;

   tcm_regif #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFFSET(CTRL_OFFSET)
   ) regif_i (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .busy(busy), .wcf_active(wc_flush_req),
      .cmd_valid(cmd_valid), .cmd(cmd), .reg_rdata(reg_rdata)
   );

   tcm_seq #(
      .LINES(LINES), .WB_ON_INVAL(WB_ON_INVAL)
   ) seq_i (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd(cmd),
      .wcf_done(wc_flush_done), .wb_ack(wb_ack),
      .line_valid(valid_vec[line_idx]), .line_dirty(dirty_vec[line_idx]),
      .busy(busy), .wcf_active(wc_flush_req), .wb_req(wb_req),
      .line_idx(line_idx), .mt_upd(mt_upd), .mt_keep_valid(mt_keep_valid)
   );

   assign wb_line  = line_idx;
   assign lk_stall = lk_valid && busy;
   assign lk_done  = lk_valid && !busy;
   assign lk_hit   = lk_done && valid_vec[lk_idx];

   tcm_line_array #(
      .LINES(LINES)
   ) array_i (
      .clk(clk), .rst_n(rst_n),
      .lk_upd(lk_done), .lk_idx(lk_idx), .lk_write(lk_write),
      .mt_upd(mt_upd), .mt_idx(line_idx), .mt_keep_valid(mt_keep_valid),
      .valid_vec(valid_vec), .dirty_vec(dirty_vec)
   );

   // R9
   wcf_before_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wc_flush_req |-> !wb_req && busy);

   // R3
   wb_only_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req |-> valid_vec[wb_line] && dirty_vec[wb_line]);
endmodule

// File: tb/tcm_ctrl_tb.sv
module tcm_ctrl_tb_top;
   localparam int LINES  = 16;
   localparam int IDX_W  = 4;
   localparam int ADDR_W = 12;
   localparam int DATA_W = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr_en = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic [DATA_W-1:0] reg_wdata = '0;
   logic [DATA_W-1:0] reg_rdata;
   logic wc_flush_req;
   logic wc_flush_done = 1'b0;
   logic wb_req;
   logic [IDX_W-1:0] wb_line;
   logic wb_ack = 1'b0;
   logic lk_valid = 1'b0;
   logic [IDX_W-1:0] lk_idx = '0;
   logic lk_write = 1'b0;
   logic lk_stall, lk_done, lk_hit;

   always #5 clk = ~clk;

   tcm_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .wc_flush_req(wc_flush_req), .wc_flush_done(wc_flush_done),
      .wb_req(wb_req), .wb_line(wb_line), .wb_ack(wb_ack),
      .lk_valid(lk_valid), .lk_idx(lk_idx), .lk_write(lk_write),
      .lk_stall(lk_stall), .lk_done(lk_done), .lk_hit(lk_hit)
   );

   int n_chk = 0;
   int n_bad = 0;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "WATCHDOG", 0, 1);
      finish_run();
   end

   // write-back responder
   int ack_dly = 2;
   int ack_cnt = 0;
   logic [LINES-1:0] wb_seen = '0;
   int wb_last = -1;
   int wb_order_bad = 0;
   int wb_hold_bad = 0;
   logic [IDX_W-1:0] wb_held = '0;
   initial begin
      forever begin
         @(negedge clk);
         if (wb_ack) begin
            wb_ack = 1'b0;
         end else if (wb_req) begin
            if (ack_cnt > 0 && wb_line != wb_held) wb_hold_bad++;
            wb_held = wb_line;
            if (ack_cnt >= ack_dly) begin
               wb_ack = 1'b1;
               if (int'(wb_line) <= wb_last) wb_order_bad++;
               wb_last = int'(wb_line);
               wb_seen[wb_line] = 1'b1;
               ack_cnt = 0;
            end else begin
               ack_cnt++;
            end
         end
      end
   end

   // write-combiner responder
   int wcf_dly = 3;
   int wcf_cnt = 0;
   int wcf_cycles = 0;
   int wcf_bad = 0;
   initial begin
      forever begin
         @(negedge clk);
         if (wc_flush_done) begin
            wc_flush_done = 1'b0;
         end else if (wc_flush_req) begin
            wcf_cycles++;
            if (wb_req) wcf_bad++;
            if (wcf_cnt >= wcf_dly) begin
               wc_flush_done = 1'b1;
               wcf_cnt = 0;
            end else begin
               wcf_cnt++;
            end
         end
      end
   end

   task automatic clear_wb_log();
      wb_seen = '0; wb_last = -1; wb_order_bad = 0; wb_hold_bad = 0;
   endtask

   task automatic reg_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0; reg_addr = 12'h030; reg_wdata = '0;
   endtask

   task automatic wait_idle();
      int guard = 0;
      while (reg_rdata[0] && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
   endtask

   task automatic lookup(input int idx, input bit wr, output bit hit);
      @(negedge clk);
      lk_valid = 1'b1; lk_idx = IDX_W'(idx); lk_write = wr;
      #1 hit = lk_hit;
      @(negedge clk);
      lk_valid = 1'b0; lk_write = 1'b0;
   endtask

   task automatic probe_valid(output logic [LINES-1:0] m);
      bit h;
      m = '0;
      for (int i = 0; i < LINES; i++) begin
         lookup(i, 1'b0, h);
         m[i] = h;
      end
   endtask

   task automatic run_op(input logic [1:0] mode, input bit wcf);
      reg_write(12'h030, {23'd0, wcf, 5'd0, mode, 1'b1});
      wait_idle();
   endtask

   task automatic preload(input logic [LINES-1:0] dm, input logic [LINES-1:0] cm);
      bit h;
      for (int i = 0; i < LINES; i++) begin
         if (dm[i]) lookup(i, 1'b1, h);
         else if (cm[i]) lookup(i, 1'b0, h);
      end
   endtask

   typedef struct packed {
      logic [15:0] dmask;
      logic [15:0] cmask;
      logic [1:0]  mode;
      logic        wcf;
      logic [15:0] exp_wb;
      logic [15:0] exp_val;
   } vec_t;

   localparam vec_t VECS [0:5] = '{
      '{16'h00F0, 16'h0F00, 2'd0, 1'b0, 16'h00F0, 16'h0000},
      '{16'h00F0, 16'h0F00, 2'd1, 1'b0, 16'h0000, 16'h0000},
      '{16'h00F0, 16'h0F00, 2'd2, 1'b0, 16'h00F0, 16'h0FF0},
      '{16'h8001, 16'h0000, 2'd2, 1'b1, 16'h8001, 16'h8001},
      '{16'hFFFF, 16'h0000, 2'd0, 1'b0, 16'hFFFF, 16'h0000},
      '{16'h0000, 16'hAAAA, 2'd0, 1'b1, 16'h0000, 16'h0000}
   };

   initial begin
      bit h;
      int cnt;
      logic [LINES-1:0] vm;
      reg_addr = 12'h030;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(reg_rdata == '0, "R1 ctrl readback", reg_rdata, 0);
      check(!wb_req && !wc_flush_req, "R1 requests idle", {wb_req, wc_flush_req}, 0);
      lookup(3, 1'b0, h);
      check(h == 1'b0, "R1 R12 miss after reset", h, 0);
      lookup(3, 1'b0, h);
      check(h == 1'b1, "R12 hit after allocate", h, 1);

      // R2 other address ignored and reads 0
      reg_write(12'h034, 32'h0000_0003);
      check(reg_rdata[0] == 1'b0, "R2 write elsewhere starts nothing", reg_rdata[0], 0);
      reg_addr = 12'h034;
      #1 check(reg_rdata == '0, "R2 read elsewhere", reg_rdata, 0);
      reg_addr = 12'h030;

      // R11 reserved mode
      reg_write(12'h030, 32'h0000_0007);
      check(reg_rdata[0] == 1'b0, "R11 mode 3 no busy", reg_rdata[0], 0);

      // vector table
      for (int v = 0; v < 6; v++) begin
         run_op(2'd1, 1'b0);
         preload(VECS[v].dmask, VECS[v].cmask);
         clear_wb_log();
         wcf_cycles = 0; wcf_bad = 0;
         run_op(VECS[v].mode, VECS[v].wcf);
         check(wb_seen == VECS[v].exp_wb, "R3 R4 R5 write-back set", wb_seen, VECS[v].exp_wb);
         check(wb_order_bad == 0 && wb_hold_bad == 0, "R6 R7 order and hold",
               wb_order_bad + wb_hold_bad, 0);
         if (VECS[v].wcf)
            check(wcf_cycles > wcf_dly && wcf_bad == 0, "R9 flush before walk", wcf_cycles, wcf_dly + 1);
         check(reg_rdata[2:1] == VECS[v].mode, "R2 mode readback", reg_rdata[2:1], VECS[v].mode);
         probe_valid(vm);
         check(vm == VECS[v].exp_val, "R3 R4 R5 valid after op", vm, VECS[v].exp_val);
      end

      // R5 repeated clean issues nothing
      run_op(2'd1, 1'b0);
      preload(16'h0010, 16'h0000);
      run_op(2'd2, 1'b0);
      clear_wb_log();
      run_op(2'd2, 1'b0);
      check(wb_seen == '0, "R5 second clean no write-back", wb_seen, 0);

      // R6 exact busy length
      run_op(2'd1, 1'b0);
      reg_write(12'h030, 32'h0000_0003);
      cnt = 0;
      while (reg_rdata[0] && cnt < 100) begin
         cnt++;
         @(negedge clk);
      end
      check(cnt == LINES, "R6 busy cycles", cnt, LINES);

      // R8 write while busy ignored
      preload(16'h0020, 16'h0000);
      ack_dly = 6;
      @(negedge clk);
      reg_wr_en = 1'b1; reg_wdata = 32'h0000_0005;
      @(negedge clk);
      reg_wdata = 32'h0000_0001;
      @(negedge clk);
      reg_wr_en = 1'b0; reg_wdata = '0;
      wait_idle();
      ack_dly = 2;
      check(reg_rdata[2:1] == 2'd2, "R8 mode unchanged", reg_rdata[2:1], 2);
      @(negedge clk);
      check(reg_rdata[0] == 1'b0, "R8 no second op", reg_rdata[0], 0);
      lookup(5, 1'b0, h);
      check(h == 1'b1, "R8 line kept valid", h, 1);

      // R9 flush only, readback bit 8
      preload(16'h0040, 16'h0000);
      clear_wb_log();
      wcf_dly = 4;
      reg_write(12'h030, 32'h0000_0100);
      check(reg_rdata[8] && reg_rdata[0] && wc_flush_req, "R9 flush phase visible",
            reg_rdata[8:0], 9'h101 | {7'd0, reg_rdata[2:1], 1'b0});
      wait_idle();
      wcf_dly = 3;
      check(wb_seen == '0, "R9 flush only no walk", wb_seen, 0);
      lookup(6, 1'b0, h);
      check(h == 1'b1, "R9 dirty line untouched", h, 1);

      // R10 lookup during busy
      run_op(2'd1, 1'b0);
      reg_write(12'h030, 32'h0000_0003);
      lk_valid = 1'b1; lk_idx = 4'd2; lk_write = 1'b1;
      #1 check(lk_stall && !lk_done, "R10 stall while busy", {lk_stall, lk_done}, 2'b10);
      cnt = 0;
      while (!lk_done && cnt < 100) begin
         @(negedge clk);
         #1 cnt++;
      end
      check(lk_done && !lk_hit, "R10 completes after busy", {lk_done, lk_hit}, 2'b10);
      @(negedge clk);
      lk_valid = 1'b0; lk_write = 1'b0;
      clear_wb_log();
      run_op(2'd2, 1'b0);
      check(wb_seen == 16'h0004, "R10 R12 late lookup marked dirty", wb_seen, 16'h0004);

      finish_run();
   end
endmodule